// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Scheduler

This block owns the refresh duty of an asynchronous DRAM array. After reset it holds every strobe inactive for the power-up settling time. It then runs a fixed number of initialization refresh cycles and afterwards issues one refresh per refresh interval. All of its timing is given in nanoseconds as parameters and turned into whole clock cycles, rounded up, at elaboration.

Each refresh needs the memory bus, so the block raises `req` to an external access arbiter. It starts a cycle only after `gnt` is seen while `req` is high. Refreshes the arbiter cannot serve at once are counted up to a limit. When that limit is reached the block raises `urgent`, so that the arbiter places refresh ahead of new accesses.

Two refresh styles can be chosen per cycle:
- **CAS-before-RAS:** the DRAM uses its own row counter.
- **RAS-only:** the block drives a row address taken from its own wrapping row counter.

The write strobe is held high at all times, so a refresh cycle is never taken as a test-mode entry.

Top module: `dref_sched`

## Requirements
- R1: From reset release, `req` stays low for ceil(PWRUP_NS/CLK_NS) cycles. During that time `ras_n`, `cas_n` and `we_n` are 1 and `addr_oe` is 0. `req` rises exactly that many clock edges after release.
- R2: Exactly INIT_CYCLES refresh cycles (falls of `ras_n`) take place before `init_done` goes to 1. No periodic refresh and no `urgent` happen before `init_done`.
- R3: A refresh cycle starts only at a clock edge where `req` and `gnt` are both 1. While `gnt` is 0, `req` stays at 1 and `ras_n` stays at 1. `bus_own` is 1 from the edge after the grant until the cycle ends, and `req` is 0 whenever `bus_own` is 1.
- R4: In a CAS-before-RAS cycle (`ras_only_sel`=0 at the grant), `cas_n` goes to 0 at least one cycle before `ras_n` falls and stays 0 for the whole time `ras_n` is 0.
- R5: `we_n` is 1 in every cycle after reset, including around every fall of `ras_n`.
- R6: `ras_n` stays 0 for exactly max(ceil of the RAS pulse, CAS hold, row-address hold and WE hold times) cycles, which is 6 at the defaults. It stays 1 for at least ceil(T_RP_NS/CLK_NS) cycles (4 at the defaults) between refresh cycles.
- R7: In a RAS-only cycle (`ras_only_sel`=1 at the grant), `addr_oe` is 1 and `cas_n` is 1 while `ras_n` is 0. `addr` holds the zero-extended row number, stable while `ras_n` is 0. The row number starts at 0 after reset and rises by one after each RAS-only cycle, wrapping at 2^ROW_W.
- R8: After `init_done`, with `gnt` held at 1, successive refreshes start exactly ceil(REFI_NS/CLK_NS) cycles apart.
- R9: Refresh intervals that elapse without a grant are counted up to MAX_DEFER; further ones are dropped. `urgent` is 1 exactly while the count equals MAX_DEFER. Each granted refresh retires one, so granting after saturation yields exactly MAX_DEFER back-to-back cycles before `req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_only_sel | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS; sampled at the grant |
| gnt | input | 1 | Bus grant from the access arbiter |
| req | output | 1 | Refresh request to the arbiter |
| urgent | output | 1 | Deferral limit reached; refresh should win over new accesses |
| bus_own | output | 1 | The block is running a refresh cycle on the bus |
| init_done | output | 1 | Initialization refresh cycles complete; normal accesses may start |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| addr_oe | output | 1 | Address bus driven by this block |
| addr | output | ADDR_W | Row address for RAS-only refresh |

## Verification
The assertions watch, on every cycle, the following:
- the strobe ordering of both refresh styles;
- the minimum low and high widths of `ras_n`;
- address stability during a RAS-only row strobe;
- the quiet power-up window;
- the exclusion of `req` while the block owns the bus.

Some behaviours need long stretches of stimulus and can only be shown by the bench's scenarios:
- the count of initialization cycles;
- the exact refresh spacing;
- the hold of a request without grant;
- the saturation and draining of the deferral count;
- the incrementing row sequence.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_PRE
  } dref_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dref_tick.sv
module dref_tick #(
  parameter int unsigned PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  assign wrap = (cnt_q == W'(PERIOD - 1));
  assign tick = en && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dref_backlog.sv
module dref_backlog #(
  parameter int unsigned MAX_DEFER = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add,
  input  logic take,
  output logic pending,
  output logic full
);
  localparam int unsigned W = $clog2(MAX_DEFER + 1);

  logic [W-1:0] lvl_q, lvl_d;
  logic         inc, dec;

  assign full    = (lvl_q == W'(MAX_DEFER));
  assign pending = (lvl_q != '0);
  assign inc     = add && !full;
  assign dec     = take && pending;

  always_comb begin
    lvl_d = lvl_q;
    if (inc && !dec)      lvl_d = lvl_q + 1'b1;
    else if (dec && !inc) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/dref_seq.sv
module dref_seq
  import dref_pkg::*;
#(
  parameter int unsigned PWR_CYC = 20000,
  parameter int unsigned SET_CYC = 1,
  parameter int unsigned ACT_CYC = 6,
  parameter int unsigned PRE_CYC = 4,
  parameter int unsigned ROW_W   = 10,
  parameter int unsigned ADDR_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              need,
  input  logic              gnt,
  input  logic              ras_only_sel,
  output logic              req,
  output logic              bus_own,
  output logic              cyc_done,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              addr_oe,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned TMAX = max2(max2(PWR_CYC, SET_CYC), max2(ACT_CYC, PRE_CYC));
  localparam int unsigned CW   = $clog2(TMAX + 1);

  dref_state_e       st_q, st_d;
  logic [CW-1:0]     tc_q, tc_d;
  logic              ror_q, ror_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic              ras_q, cas_q, oe_q;
  logic              ras_d, cas_d, oe_d;
  logic              tc_zero, strobe_phase;

  assign tc_zero = (tc_q == '0);

  always_comb begin
    st_d     = st_q;
    tc_d     = tc_q;
    ror_d    = ror_q;
    row_d    = row_q;
    cyc_done = 1'b0;
    case (st_q)
      ST_PWR: begin
        if (tc_zero) st_d = ST_IDLE;
        else         tc_d = tc_q - 1'b1;
      end
      ST_IDLE: begin
        if (need && gnt) begin
          st_d  = ST_SETUP;
          tc_d  = CW'(SET_CYC - 1);
          ror_d = ras_only_sel;
        end
      end
      ST_SETUP: begin
        if (tc_zero) begin
          st_d = ST_ACT;
          tc_d = CW'(ACT_CYC - 1);
        end else tc_d = tc_q - 1'b1;
      end
      ST_ACT: begin
        if (tc_zero) begin
          st_d = ST_PRE;
          tc_d = CW'(PRE_CYC - 1);
        end else tc_d = tc_q - 1'b1;
      end
      ST_PRE: begin
        if (tc_zero) begin
          st_d     = ST_IDLE;
          cyc_done = 1'b1;
          if (ror_q) row_d = row_q + 1'b1;
        end else tc_d = tc_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes are registered from the next state so they change cleanly on edges
  assign strobe_phase = (st_d == ST_SETUP) || (st_d == ST_ACT);
  assign ras_d = !(st_d == ST_ACT);
  assign cas_d = !(strobe_phase && !ror_d);
  assign oe_d  = strobe_phase && ror_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PWR;
      tc_q  <= CW'(PWR_CYC - 1);
      ror_q <= 1'b0;
      row_q <= '0;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tc_q  <= tc_d;
      ror_q <= ror_d;
      row_q <= row_d;
      ras_q <= ras_d;
      cas_q <= cas_d;
      oe_q  <= oe_d;
    end
  end

  assign req     = (st_q == ST_IDLE) && need;
  assign bus_own = (st_q == ST_SETUP) || (st_q == ST_ACT) || (st_q == ST_PRE);
  assign ras_n   = ras_q;
  assign cas_n   = cas_q;
  assign we_n    = 1'b1;
  assign addr_oe = oe_q;
  assign addr    = ADDR_W'(row_q);
endmodule

// File: rtl/dref_sched.sv
module dref_sched
  import dref_pkg::*;
#(
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned PWRUP_NS    = 200000,
  parameter int unsigned REFI_NS     = 15600,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned MAX_DEFER   = 8,
  parameter int unsigned ROW_W       = 10,
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned T_CSR_NS    = 5,
  parameter int unsigned T_CHR_NS    = 10,
  parameter int unsigned T_WSU_NS    = 10,
  parameter int unsigned T_WHD_NS    = 10,
  parameter int unsigned T_RAS_NS    = 60,
  parameter int unsigned T_RAH_NS    = 10,
  parameter int unsigned T_RP_NS     = 40,
  parameter int unsigned T_RPC_NS    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_only_sel,
  input  logic              gnt,
  output logic              req,
  output logic              urgent,
  output logic              bus_own,
  output logic              init_done,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              addr_oe,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned PWR_CYC = max2(1, ns_to_cyc(PWRUP_NS, CLK_NS));
  localparam int unsigned REF_CYC = max2(1, ns_to_cyc(REFI_NS, CLK_NS));
  localparam int unsigned SET_CYC = max2(1, max2(ns_to_cyc(T_CSR_NS, CLK_NS),
                                                 ns_to_cyc(T_WSU_NS, CLK_NS)));
  localparam int unsigned ACT_CYC = max2(1, max2(max2(ns_to_cyc(T_RAS_NS, CLK_NS),
                                                      ns_to_cyc(T_CHR_NS, CLK_NS)),
                                                 max2(ns_to_cyc(T_RAH_NS, CLK_NS),
                                                      ns_to_cyc(T_WHD_NS, CLK_NS))));
  localparam int unsigned PRE_CYC = max2(1, max2(ns_to_cyc(T_RP_NS, CLK_NS),
                                                 ns_to_cyc(T_RPC_NS, CLK_NS)));
  localparam int unsigned IW      = $clog2(INIT_CYCLES + 1);

  logic          tick, pending, full, cyc_done, need;
  logic [IW-1:0] init_q, init_d;

  assign init_done = (init_q == IW'(INIT_CYCLES));
  assign need      = !init_done || pending;
  assign urgent    = full;

  always_comb begin
    init_d = init_q;
    if (cyc_done && !init_done) init_d = init_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= '0;
    else        init_q <= init_d;
  end

  dref_tick #(.PERIOD(REF_CYC)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (init_done),
    .tick (tick)
  );

  dref_backlog #(.MAX_DEFER(MAX_DEFER)) u_backlog (
    .clk    (clk),
    .rst_n  (rst_n),
    .add    (tick),
    .take   (cyc_done && init_done),
    .pending(pending),
    .full   (full)
  );

  dref_seq #(
    .PWR_CYC(PWR_CYC),
    .SET_CYC(SET_CYC),
    .ACT_CYC(ACT_CYC),
    .PRE_CYC(PRE_CYC),
    .ROW_W  (ROW_W),
    .ADDR_W (ADDR_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .need        (need),
    .gnt         (gnt),
    .ras_only_sel(ras_only_sel),
    .req         (req),
    .bus_own     (bus_own),
    .cyc_done    (cyc_done),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .addr_oe     (addr_oe),
    .addr        (addr)
  );
endmodule

// File: rtl/dref_sched_chk.sv
module dref_sched_chk #(
  parameter int unsigned PWR_CYC = 20000,
  parameter int unsigned ACT_CYC = 6,
  parameter int unsigned PRE_CYC = 4,
  parameter int unsigned ADDR_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              urgent,
  input logic              bus_own,
  input logic              init_done,
  input logic              ras_n,
  input logic              cas_n,
  input logic              addr_oe,
  input logic [ADDR_W-1:0] addr
);
  localparam int unsigned PW = $clog2(PWR_CYC + 1);
  localparam int unsigned LMAX = (ACT_CYC > PRE_CYC) ? ACT_CYC : PRE_CYC;
  localparam int unsigned LW = $clog2(LMAX + 2);

  logic [PW-1:0] since_q;
  logic [LW-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      lo_q    <= '0;
      hi_q    <= LW'(PRE_CYC);
    end else begin
      if (since_q != PW'(PWR_CYC)) since_q <= since_q + 1'b1;
      if (ras_n) lo_q <= '0;
      else if (lo_q != LW'(LMAX + 1)) lo_q <= lo_q + 1'b1;
      if (!ras_n) hi_q <= '0;
      else if (hi_q != LW'(LMAX + 1)) hi_q <= hi_q + 1'b1;
    end
  end

  AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < PW'(PWR_CYC)) |-> (!req && ras_n && cas_n && !addr_oe)); // R1
  AST_NO_URGENT_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !urgent); // R2
  AST_REQ_OFF_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> !req); // R3
  AST_RAS_ONLY_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> bus_own); // R3
  AST_CBR_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !addr_oe) |-> $past(!cas_n)); // R4
  AST_CBR_CAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !addr_oe) |-> !cas_n); // R4
  AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_q >= LW'(ACT_CYC))); // R6
  AST_RAS_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_q >= LW'(PRE_CYC))); // R6
  AST_ROR_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> cas_n); // R7
  AST_ROR_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n) && addr_oe) |-> $stable(addr)); // R7
endmodule

bind dref_sched dref_sched_chk #(
  .PWR_CYC(PWR_CYC),
  .ACT_CYC(ACT_CYC),
  .PRE_CYC(PRE_CYC),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .urgent   (urgent),
  .bus_own  (bus_own),
  .init_done(init_done),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .addr_oe  (addr_oe),
  .addr     (addr)
);

// File: tb/tb_dref_sched.sv
`timescale 1ns/1ps
module tb_dref_sched;
  localparam int PWR = 100;   // 1000 ns / 10 ns
  localparam int REF = 200;   // 2000 ns / 10 ns
  localparam int ACT = 6;
  localparam int PRE = 4;
  localparam int NINIT = 8;
  localparam int MAXD = 3;

  logic clk, rst_n, ras_only_sel, gnt;
  logic req, urgent, bus_own, init_done, ras_n, cas_n, we_n, addr_oe;
  logic [10:0] addr;

  int total = 0, bad = 0;
  int cyc = 0;
  int fall_cnt = 0, last_fall_cyc = 0;
  logic [10:0] fall_addr;
  int lo_len = 0, hi_len = 1000;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0;

  dref_sched #(.CLK_NS(10), .PWRUP_NS(1000), .REFI_NS(2000),
               .INIT_CYCLES(NINIT), .MAX_DEFER(MAXD)) dut (
    .clk(clk), .rst_n(rst_n), .ras_only_sel(ras_only_sel), .gnt(gnt),
    .req(req), .urgent(urgent), .bus_own(bus_own), .init_done(init_done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr_oe(addr_oe), .addr(addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // strobe monitor, sampled at the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) v_r5++;
      if (prev_ras && !ras_n) begin
        fall_cnt++;
        last_fall_cyc = cyc;
        fall_addr = addr;
        if (hi_len < PRE) v_r6++;
        if (!addr_oe && prev_cas) v_r4++;
        lo_len = 0;
      end
      if (!ras_n) begin
        lo_len++;
        if (!addr_oe && cas_n) v_r4++;
        if (addr_oe && (!cas_n || addr != fall_addr)) v_r7++;
      end else begin
        if (!prev_ras && lo_len != ACT) v_r6++;
        if (!prev_ras) hi_len = 0;
        hi_len++;
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_and_powerup();
    int n;
    rst_n = 1'b0; gnt = 1'b1; ras_only_sel = 1'b0;
    wait_neg(3);
    check(ras_n && cas_n && we_n && !req && !addr_oe && !init_done && !bus_own,
          "R1 reset state", {ras_n, cas_n, we_n, req, addr_oe}, 5'b11100);
    rst_n = 1'b1;
    n = 0;
    while (!req && n < 300) begin
      @(negedge clk); n++;
      if (!req) check(ras_n && cas_n && !addr_oe, "R1 quiet during wait", ras_n, 1);
    end
    check(n == PWR, "R1 cycles to first request despite gnt", n, PWR);
  endtask

  task automatic t_init();
    int n = 0;
    while (!init_done && n < 500) begin @(negedge clk); n++; end
    check(fall_cnt == NINIT, "R2 init refresh count", fall_cnt, NINIT);
    check(!urgent, "R2 no urgent at init end", urgent, 0);
    wait_neg(150);
    check(fall_cnt == NINIT, "R2 no extra refresh before first interval", fall_cnt, NINIT);
  endtask

  task automatic t_interval();
    int f0, t1, n;
    f0 = fall_cnt; n = 0;
    while (fall_cnt < f0 + 1 && n < 400) begin @(negedge clk); n++; end
    t1 = last_fall_cyc;
    n = 0;
    while (fall_cnt < f0 + 2 && n < 400) begin @(negedge clk); n++; end
    check(last_fall_cyc - t1 == REF, "R8 refresh spacing", last_fall_cyc - t1, REF);
  endtask

  task automatic t_grant_wait();
    int n = 0;
    bit held = 1'b1;
    gnt = 1'b0;
    while (!req && n < 400) begin @(negedge clk); n++; end
    check(req, "R3 request raised", req, 1);
    repeat (30) begin
      @(negedge clk);
      if (!req || !ras_n || bus_own) held = 1'b0;
    end
    check(held, "R3 request held and no strobe without grant", held, 1);
    gnt = 1'b1;
    @(negedge clk);
    check(bus_own && !req && ras_n && !cas_n, "R3 R4 setup phase after grant",
          {bus_own, req, ras_n, cas_n}, 4'b1010);
    @(negedge clk);
    check(!ras_n, "R3 row strobe one cycle after setup", ras_n, 0);
  endtask

  task automatic t_backlog(input bit ror, output int first_row);
    int n = 0, f0;
    gnt = 1'b0;
    ras_only_sel = ror;
    wait_neg(20);
    while (!urgent && n < 1000) begin @(negedge clk); n++; end
    check(urgent && req, "R9 urgent at deferral limit", urgent, 1);
    wait_neg(REF + 10);
    check(urgent, "R9 urgent stays while saturated", urgent, 1);
    f0 = fall_cnt;
    gnt = 1'b1;
    n = 0;
    first_row = -1;
    for (int i = 0; i < MAXD; i++) begin
      while (fall_cnt == f0 + i && n < 200) begin @(negedge clk); n++; end
      if (ror) begin
        if (i == 0) first_row = fall_addr;
        check(addr_oe && cas_n, "R7 address driven with cas high", {addr_oe, cas_n}, 2'b11);
        check(fall_addr == i, "R7 row sequence", fall_addr, i);
      end
    end
    n = 0;
    while ((req || bus_own) && n < 100) begin @(negedge clk); n++; end
    check(fall_cnt - f0 == MAXD, "R9 deferred refreshes served", fall_cnt - f0, MAXD);
    check(!urgent && !addr_oe, "R9 urgent cleared after drain", urgent, 0);
  endtask

  task automatic t_monitor_results();
    check(v_r4 == 0, "R4 cas-before-ras ordering", v_r4, 0);
    check(v_r5 == 0, "R5 write strobe high", v_r5, 0);
    check(v_r6 == 0, "R6 row strobe widths", v_r6, 0);
    check(v_r7 == 0, "R7 ras-only address and cas", v_r7, 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int r;
    t_reset_and_powerup();
    t_init();
    t_interval();
    t_grant_wait();
    t_backlog(1'b0, r);
    t_backlog(1'b1, r);
    check(r == 0, "R7 first ras-only row after reset", r, 0);
    t_monitor_results();
    finish_run();
  end
endmodule